// File: doc/BRIEF.md
# Page Write and Self-Timed Programming Controller

This controller sits between the serial command front end and a byte-wide register-file memory. A write command opens with a start pulse that carries the target address and the current state of the write-enable latch. Data bytes then arrive on a valid/ready stream and are gathered into a page buffer. The page holds `2**PAGE_W` bytes, 32 by default. Each accepted byte advances only the in-page offset, so a long command wraps and overwrites the earliest slots of the same page. When the command ends, the controller runs a self-timed programming cycle of `CYCLE_CLKS` clocks. During that cycle it commits every filled slot through the memory write port. A slot is skipped when its address is flagged as protected.

While the cycle runs, `busy` is high. The controller then ignores new command starts and holds the byte stream's ready low. The status byte it returns reads as all ones. The stream rule is that a byte moves only on a clock edge where `in_valid` and `in_ready` are both high. Ready is high only while a write command is collecting, and the source must hold its byte until it is taken. When the cycle finishes, the controller pulses a clear to the write-enable latch.

Top module: `page_prog_ctrl`

## Requirements
- R1: A command whose start address has offset `o` and page `p` places its byte `i` at address `{p, (o+i) mod 32}`. The upper address bits never change within one programming cycle.
- R2: When a command carries more than 32 bytes, the later byte wins at each reused offset, and the memory receives only the final contents of each slot.
- R3: If `wel_set` was 1 at `cmd_start` and at least one byte was accepted, then `busy` rises on the clock after `cmd_end` and stays high for exactly `CYCLE_CLKS` cycles. Memory writes happen only while `busy` is high.
- R4: A command started while `wel_set` is 0 is discarded. `busy` stays 0 and no memory location changes.
- R5: A command that ends with no byte accepted starts no cycle and writes nothing.
- R6: A slot whose address has `prot_hit` high is not written, and the unprotected slots of the same page are still written.
- R7: While `busy` is high, `in_ready` is 0 and `cmd_start` has no effect: after the cycle ends, `in_ready` stays 0.
- R8: While `busy` is high, `stat_out` is 8'hFF. Otherwise `stat_out` is `{stat_flags, 1'b0}`, with bit 0 serving as the in-progress bit.
- R9: `wel_clr` is high for exactly one cycle per programming cycle, in the last cycle that `busy` is high.
- R10: After reset, `busy`, `in_ready`, `mem_we` and `wel_clr` are 0.
- R11: `in_ready` is 1 from the clock after an accepted `cmd_start` until `cmd_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Write command begins (pulse) |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| wel_set | input | 1 | Write-enable latch state, sampled at cmd_start |
| in_valid | input | 1 | Data byte valid |
| in_data | input | DATA_W | Data byte |
| in_ready | output | 1 | Controller can take a byte |
| cmd_end | input | 1 | Chip deselect seen (pulse) |
| prot_hit | input | 1 | Address on mem_addr is protected |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | Clear the write-enable latch |
| stat_flags | input | DATA_W-1 | Status bits 7..1 from the status path |
| stat_out | output | DATA_W | Status byte seen by the reader |

## Verification
A corrupted offset pointer or page base shows up as a misplaced or missing byte in the modelled memory. That error becomes visible at the comparison made as soon as `busy` falls. A slot-valid mask that is stuck or not cleared produces stray writes from an earlier command, or a cycle started by an empty command. Either is caught by the full-memory comparison or by the busy-length count within about `CYCLE_CLKS` cycles of `cmd_end`. A state register that leaves the programming state early or late changes the number of busy cycles and moves the `wel_clr` pulse, which is checked against the count on every command.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_PROG    = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_page_buffer.sv
module pgw_page_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (wr_en) begin
      fill_q[wr_idx] <= 1'b1;
      slot_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data   = slot_q[rd_idx];
  assign rd_valid  = fill_q[rd_idx];
  assign any_valid = |fill_q;
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
  parameter int CYCLE_CLKS = 250000,
  localparam int CW = $clog2(CYCLE_CLKS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign last = run && (cnt == CW'(CYCLE_CLKS - 1));
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 5,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wel_set,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              cmd_end,
  input  logic              prot_hit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              wel_clr,
  input  logic [DATA_W-2:0] stat_flags,
  output logic [DATA_W-1:0] stat_out
);
  import pgw_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W     = ADDR_W - PAGE_W;
  localparam int CW         = $clog2(CYCLE_CLKS) + 1;

  pgw_state_e        state_q;
  logic [BASE_W-1:0] base_q;
  logic [PAGE_W-1:0] ptr_q;
  logic              accept, open_cmd, any_fill, slot_fill, tmr_last;
  logic [CW-1:0]     tmr_cnt;
  logic [DATA_W-1:0] slot_data;

  assign open_cmd = (state_q == ST_IDLE) && cmd_start && wel_set;
  assign in_ready = (state_q == ST_COLLECT);
  assign accept   = in_ready && in_valid;
  assign busy     = (state_q == ST_PROG);

  pgw_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (open_cmd),
    .wr_en    (accept),
    .wr_idx   (ptr_q),
    .wr_data  (in_data),
    .rd_idx   (tmr_cnt[PAGE_W-1:0]),
    .rd_data  (slot_data),
    .rd_valid (slot_fill),
    .any_valid(any_fill)
  );

  pgw_prog_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .cnt  (tmr_cnt),
    .last (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (open_cmd) begin
          state_q <= ST_COLLECT;
          base_q  <= start_addr[ADDR_W-1:PAGE_W];
          ptr_q   <= start_addr[PAGE_W-1:0];
        end
        ST_COLLECT: begin
          if (accept) ptr_q <= ptr_q + 1'b1;
          if (cmd_end) state_q <= (any_fill || accept) ? ST_PROG : ST_IDLE;
        end
        ST_PROG: if (tmr_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // One slot per clock during the first PAGE_BYTES cycles of the timed window.
  assign mem_addr  = {base_q, tmr_cnt[PAGE_W-1:0]};
  assign mem_wdata = slot_data;
  assign mem_we    = busy && (tmr_cnt < CW'(PAGE_BYTES)) && slot_fill && !prot_hit;
  assign wel_clr   = tmr_last;
  assign stat_out  = busy ? '1 : {stat_flags, 1'b0};
endmodule

// File: rtl/page_prog_ctrl_chk.sv
module page_prog_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_end,
  input logic              prot_hit,
  input logic              in_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              wel_clr,
  input logic [DATA_W-1:0] stat_out
);
  a_r3_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r3_rise_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_end));
  a_r1_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));
  a_r6_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |-> !mem_we);
  a_r7_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  a_r8_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stat_out == '1));
  a_r8_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stat_out[0]);
  a_r9_clr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy);
  a_r9_clr_last: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);
endmodule

bind page_prog_ctrl page_prog_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .prot_hit(prot_hit), .in_ready(in_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy), .wel_clr(wel_clr), .stat_out(stat_out)
);

// File: tb/test_page_prog_ctrl.sv
module test_page_prog_ctrl;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int CYC    = 40;
  localparam int MEMN   = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, wel_set = 0, in_valid = 0, cmd_end = 0, prot_en = 0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [DATA_W-2:0] stat_flags = 7'h53;
  logic in_ready, mem_we, busy, wel_clr, prot_hit;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, stat_out;
  logic [7:0] bmem [MEMN];
  logic [7:0] emem [MEMN];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  // Protection rule used by the bench: upper half of each page when enabled.
  assign prot_hit = prot_en && mem_addr[4];

  page_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(5), .CYCLE_CLKS(CYC)) i_page_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr), .wel_set(wel_set),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .cmd_end(cmd_end),
    .prot_hit(prot_hit), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel_clr(wel_clr), .stat_flags(stat_flags), .stat_out(stat_out)
  );

  always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {addr[10], nbytes[7], seed[8], wel[1], prot[1]}
  localparam logic [26:0] VEC [0:5] = '{
    {10'h000, 7'd4,  8'h10, 1'b1, 1'b0},
    {10'h03C, 7'd8,  8'h20, 1'b1, 1'b0},
    {10'h045, 7'd40, 8'h40, 1'b1, 1'b0},
    {10'h100, 7'd3,  8'h80, 1'b0, 1'b0},
    {10'h200, 7'd32, 8'h33, 1'b1, 1'b1},
    {10'h21E, 7'd0,  8'h55, 1'b1, 1'b0}
  };

  task automatic run_write(input logic [ADDR_W-1:0] a, input int n, input logic [7:0] seed,
                           input logic w, input logic p, input string req);
    int bcnt, ccnt, clr_at, mism;
    prot_en = p;
    @(negedge clk);
    cmd_start = 1; start_addr = a; wel_set = w;
    @(negedge clk);
    cmd_start = 0;
    if (w) check({req, " R11 ready open"}, int'(in_ready), 1);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = seed + 8'(i);
      @(negedge clk);
    end
    in_valid = 0; cmd_end = 1;
    @(negedge clk);
    cmd_end = 0;
    if (w && n > 0) begin
      for (int i = 0; i < n; i++) begin
        logic [ADDR_W-1:0] ea;
        ea = {a[ADDR_W-1:5], 5'(a[4:0] + 5'(i))};
        if (!(p && ea[4])) emem[ea] = seed + 8'(i);
      end
      check({req, " R8 status busy"}, int'(stat_out), 8'hFF);
    end
    bcnt = 0; ccnt = 0; clr_at = 0;
    while (busy && bcnt < 4 * CYC) begin
      bcnt++;
      if (wel_clr) begin ccnt++; clr_at = bcnt; end
      @(negedge clk);
    end
    check({req, " R3 busy length"}, bcnt, (w && n > 0) ? CYC : 0);
    check({req, " R9 clear count"}, ccnt, (w && n > 0) ? 1 : 0);
    if (w && n > 0) check({req, " R9 clear last"}, clr_at, CYC);
    mism = 0;
    for (int k = 0; k < MEMN; k++) if (bmem[k] !== emem[k]) mism++;
    check({req, " memory image"}, mism, 0);
    check({req, " R8 status idle"}, int'(stat_out), {stat_flags, 1'b0});
  endtask

  initial begin
    int wd = 0;
    for (int k = 0; k < MEMN; k++) begin bmem[k] = 8'h00; emem[k] = 8'h00; end
    repeat (3) @(negedge clk);
    check("R10 busy", int'(busy), 0);
    check("R10 ready", int'(in_ready), 0);
    check("R10 we", int'(mem_we), 0);
    check("R10 clr", int'(wel_clr), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      string tag;
      case (v)
        0: tag = "R1 plain"; 1: tag = "R1 wrap"; 2: tag = "R2 overflow";
        3: tag = "R4 no latch"; 4: tag = "R6 protect"; default: tag = "R5 empty";
      endcase
      run_write(VEC[v][26:17], int'(VEC[v][16:10]), VEC[v][9:2], VEC[v][1], VEC[v][0], tag);
    end

    // R7: start attempts during busy are ignored
    @(negedge clk);
    cmd_start = 1; start_addr = 10'h300; wel_set = 1;
    @(negedge clk);
    cmd_start = 0; in_valid = 1; in_data = 8'hC3;
    @(negedge clk);
    in_valid = 0; cmd_end = 1;
    @(negedge clk);
    cmd_end = 0;
    emem[10'h300] = 8'hC3;
    cmd_start = 1; start_addr = 10'h3A0;
    @(negedge clk);
    cmd_start = 0;
    check("R7 ready low in busy", int'(in_ready), 0);
    while (busy && wd < 4 * CYC) begin wd++; @(negedge clk); end
    check("R7 no open after busy", int'(in_ready), 0);
    check("R7 target untouched", int'(bmem[10'h3A0]), 0);
    check("R7 first write done", int'(bmem[10'h300]), 8'hC3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule